// File: doc/BRIEF.md
# Fixed-Point Requantizer Stage

This block takes one fixed-point sample per transfer and re-expresses it in a different fixed-point format. The source and destination formats are fixed when the block is elaborated. For each side, parameters set the word width, the number of fractional bits and the number encoding. The encoding is unsigned, two's complement or sign-magnitude.

When the destination has fewer fractional bits, the dropped bits are resolved by the selected rounding mode. When the destination has more fractional bits, the value is shifted left exactly. A value that falls outside the destination range is either clamped to the nearest representable extreme or wrapped to its low bits. A flag travels with each sample and marks a value that was changed by clamping or wrapping.

Samples move through a parameterised register pipeline with a valid/ready handshake on both sides. The output may drive several consumers. A sample leaves only in a cycle where every consumer signals ready. The pipeline closes up bubbles, so the input is refused only when every stage is occupied and the output is blocked.

Top module: `fxp_requant`

## Requirements
- R1: The input code is read according to IN_REP: 0 is unsigned, 1 is two's complement, and 2 is sign-magnitude with the sign in the MSB. A sign-magnitude negative zero reads as 0.
- R2: When OUT_FRAC is greater than IN_FRAC, the value is shifted left by the difference with no loss. The flag stays clear if the result fits the output range.
- R3: When fractional bits are dropped, RND_MODE 0 rounds toward minus infinity and RND_MODE 1 rounds toward plus infinity. This holds for both signs.
- R4: With RND_MODE 2, the result is the nearest representable value, and exact half-way values round away from zero. Overflow is judged on the rounded value.
- R5: With OVF_MODE 0, an out-of-range value becomes the largest or smallest output value. For a sign-magnitude output these are plus and minus the full magnitude field (0x7F and 0xFF for 8 bits).
- R6: With OVF_MODE 1, the output keeps the low OUT_W bits of the two's-complement form of the rounded value. A negative value sent to an unsigned output therefore wraps (-1 becomes all ones).
- R7: A sign-magnitude output never encodes zero with the sign bit set.
- R8: out_ovf is high for exactly those samples whose value was changed by clamping or wrapping. The flag is not sticky.
- R9: A sample leaves only on an edge where out_valid is high and every bit of sink_ready is high. While that does not happen, out_valid, out_data and out_ovf hold steady.
- R10: Into an empty, unblocked pipeline, a sample accepted on one edge appears at the output after STAGES edges, counting the accepting edge.
- R11: in_ready is low only when all STAGES slots hold samples and the output is blocked. No accepted sample is lost, duplicated or reordered.
- R12: Reset empties every stage. After reset, out_valid stays low until a new input has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Source offers a sample |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | IN_W | Input code in the source format |
| out_valid | output | 1 | A converted sample is offered |
| sink_ready | input | N_SINK | One ready bit per consumer |
| out_data | output | OUT_W | Output code in the destination format |
| out_ovf | output | 1 | Clamping or wrapping changed this sample |

## Verification
Two events can share a cycle: a new sample entering the pipeline, and the sample at its head being released to the consumers. The overlap also occurs while only part of the consumer set is ready. The bench provokes this with random valid and per-consumer ready patterns, with a full pipeline blocked by one consumer, and with a reset while the pipeline is full. A behavioural slot model predicts in_ready, out_valid and the converted value on every clock. Four instances with different format settings are compared at once.

// File: rtl/fxp_requant_pkg.sv
package fxp_requant_pkg;
   localparam int REP_UNS  = 0;
   localparam int REP_TWOS = 1;
   localparam int REP_SM   = 2;

   localparam int OVF_SAT  = 0;
   localparam int OVF_WRAP = 1;

   localparam int RND_FLOOR = 0;
   localparam int RND_CEIL  = 1;
   localparam int RND_NEAR  = 2;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/fxp_decode.sv
module fxp_decode #(
   parameter int W   = 8,
   parameter int REP = 1,
   parameter int XW  = 9
) (
   input  logic [W-1:0]         code,
   output logic signed [XW-1:0] val
);
   import fxp_requant_pkg::*;

   if (XW <= W) begin : g_chk
      $error("fxp_decode: XW must exceed W");
   end

   if (REP == REP_UNS) begin : g_uns
      assign val = {{(XW-W){1'b0}}, code};
   end else if (REP == REP_TWOS) begin : g_twos
      assign val = {{(XW-W){code[W-1]}}, code};
   end else begin : g_sm
      logic signed [XW-1:0] mag;
      assign mag = {{(XW-W+1){1'b0}}, code[W-2:0]};
      assign val = code[W-1] ? -mag : mag;
   end
endmodule

// File: rtl/fxp_align_round.sv
module fxp_align_round #(
   parameter int XW  = 9,
   parameter int SH  = 0,
   parameter int RND = 0,
   parameter int QW  = 12
) (
   input  logic signed [XW-1:0] val,
   output logic signed [QW-1:0] q
);
   import fxp_requant_pkg::*;

   if (QW < XW + imax(0, -SH) + 1) begin : g_chk
      $error("fxp_align_round: QW too narrow");
   end
   if (SH >= XW) begin : g_chk_sh
      $error("fxp_align_round: shift exceeds word");
   end

   if (SH <= 0) begin : g_left
      localparam int LS = -SH;
      assign q = QW'(val) <<< LS;
   end else begin : g_right
      localparam logic [SH-1:0] HALF = SH'(1) << (SH - 1);
      logic signed [XW-1:0] fl;
      logic [SH-1:0]        rem;
      logic                 inc;

      assign fl  = val >>> SH;
      assign rem = val[SH-1:0];

      always_comb begin
         if (RND == RND_FLOOR) begin
            inc = 1'b0;
         end else if (RND == RND_CEIL) begin
            inc = |rem;
         end else begin
            // half-way ties go away from zero
            inc = val[XW-1] ? (rem > HALF) : (rem >= HALF);
         end
      end

      assign q = QW'(fl) + {{(QW-1){1'b0}}, inc};
   end
endmodule

// File: rtl/fxp_saturate.sv
module fxp_saturate #(
   parameter int QW  = 12,
   parameter int W   = 8,
   parameter int REP = 1,
   parameter int OVF = 0
) (
   input  logic signed [QW-1:0] q,
   output logic [W-1:0]         code,
   output logic                 ovf
);
   import fxp_requant_pkg::*;

   localparam logic signed [QW-1:0] ONE  = QW'(1);
   localparam logic signed [QW-1:0] MAXV = (REP == REP_UNS) ? ((ONE <<< W) - ONE)
                                                             : ((ONE <<< (W - 1)) - ONE);
   localparam logic signed [QW-1:0] MINV = (REP == REP_UNS)  ? '0
                                         : (REP == REP_TWOS) ? -(ONE <<< (W - 1))
                                                             : -MAXV;

   if (QW < W + 2) begin : g_chk
      $error("fxp_saturate: QW too narrow");
   end

   logic hi, lo;
   assign hi  = q > MAXV;
   assign lo  = q < MINV;
   assign ovf = hi | lo;

   if (OVF == OVF_SAT) begin : g_sat
      logic signed [QW-1:0] qc;
      assign qc = hi ? MAXV : (lo ? MINV : q);
      if (REP == REP_SM) begin : g_sm
         logic signed [QW-1:0] aq;
         assign aq   = qc[QW-1] ? -qc : qc;
         assign code = {qc[QW-1], aq[W-2:0]};
         always_comb begin
            // R5: a clamped sign-magnitude code carries the full magnitude
            a_r5_sat_full_mag: assert (!ovf || (&code[W-2:0]));
         end
      end else begin : g_bin
         assign code = qc[W-1:0];
      end
   end else begin : g_wrap
      if (REP == REP_SM) begin : g_sm
         logic signed [QW-1:0] aq;
         logic [W-2:0]         mag;
         assign aq   = q[QW-1] ? -q : q;
         assign mag  = aq[W-2:0];
         assign code = {q[QW-1] && (|mag), mag};
      end else begin : g_bin
         assign code = q[W-1:0];
      end
   end

   if (REP == REP_SM) begin : g_zero_chk
      always_comb begin
         // R7: sign-magnitude zero is never negative
         a_r7_no_neg_zero: assert (code != {1'b1, {(W-1){1'b0}}});
      end
   end
endmodule

// File: rtl/fxp_pipe.sv
module fxp_pipe #(
   parameter int DW     = 8,
   parameter int STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [DW-1:0] in_data,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [DW-1:0] out_data
);
   localparam int CW = $clog2(STAGES + 2);

   if (STAGES < 1) begin : g_chk
      $error("fxp_pipe: STAGES must be at least 1");
   end

   logic [STAGES-1:0] v;
   logic [DW-1:0]     d  [STAGES];
   logic [STAGES:0]   adv;
   logic [STAGES:0]   cv;
   logic [DW-1:0]     cd [STAGES+1];

   always_comb begin
      adv[STAGES] = out_ready;
      for (int i = STAGES - 1; i >= 0; i--) begin
         adv[i] = !v[i] || adv[i+1];
      end
      cv = {v, in_valid};
      cd[0] = in_data;
      for (int i = 0; i < STAGES; i++) begin
         cd[i+1] = d[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v <= '0;
      end else begin
         for (int i = 0; i < STAGES; i++) begin
            if (adv[i]) v[i] <= cv[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < STAGES; i++) begin
         if (adv[i] && cv[i]) d[i] <= cd[i];
      end
   end

   assign in_ready  = adv[0];
   assign out_valid = v[STAGES-1];
   assign out_data  = d[STAGES-1];

   // occupancy tracker used only by the checks below
   logic [CW-1:0] occ;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) occ <= '0;
      else occ <= occ + CW'(in_valid && in_ready) - CW'(out_valid && out_ready);
   end

   a_r9_hold_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
   a_r11_refuse_only_full: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |-> (out_valid && !out_ready && occ == CW'(STAGES)));
   a_r11_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CW'(STAGES));
   a_r12_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (occ != '0));
endmodule

// File: rtl/fxp_requant.sv
module fxp_requant
   import fxp_requant_pkg::*;
#(
   parameter int IN_W     = 12,
   parameter int IN_FRAC  = 4,
   parameter int IN_REP   = REP_TWOS,
   parameter int OUT_W    = 8,
   parameter int OUT_FRAC = 2,
   parameter int OUT_REP  = REP_SM,
   parameter int OVF_MODE = OVF_SAT,
   parameter int RND_MODE = RND_NEAR,
   parameter int STAGES   = 3,
   parameter int N_SINK   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [IN_W-1:0]   in_data,
   output logic              out_valid,
   input  logic [N_SINK-1:0] sink_ready,
   output logic [OUT_W-1:0]  out_data,
   output logic              out_ovf
);
   localparam int XW    = IN_W + 1;
   localparam int SHIFT = IN_FRAC - OUT_FRAC;
   localparam int QW    = imax(XW + imax(0, -SHIFT), OUT_W + 1) + 2;

   if (IN_W < 2 || OUT_W < 2) begin : g_chk_w
      $error("fxp_requant: word widths must be at least 2");
   end
   if (IN_FRAC < 0 || IN_FRAC > IN_W || OUT_FRAC < 0 || OUT_FRAC > OUT_W) begin : g_chk_f
      $error("fxp_requant: fractional bit count out of range");
   end
   if (IN_REP > REP_SM || OUT_REP > REP_SM || IN_REP < 0 || OUT_REP < 0) begin : g_chk_r
      $error("fxp_requant: unknown representation");
   end
   if (OVF_MODE > OVF_WRAP || OVF_MODE < 0 || RND_MODE > RND_NEAR || RND_MODE < 0) begin : g_chk_m
      $error("fxp_requant: unknown overflow or rounding mode");
   end
   if (N_SINK < 1 || STAGES < 1) begin : g_chk_n
      $error("fxp_requant: N_SINK and STAGES must be at least 1");
   end

   logic signed [XW-1:0] val;
   logic signed [QW-1:0] q;
   logic [OUT_W-1:0]     code;
   logic                 ovf;
   logic                 all_rdy;
   logic [OUT_W:0]       head;

   fxp_decode #(.W(IN_W), .REP(IN_REP), .XW(XW)) u_dec (
      .code (in_data),
      .val  (val)
   );

   fxp_align_round #(.XW(XW), .SH(SHIFT), .RND(RND_MODE), .QW(QW)) u_rnd (
      .val (val),
      .q   (q)
   );

   fxp_saturate #(.QW(QW), .W(OUT_W), .REP(OUT_REP), .OVF(OVF_MODE)) u_sat (
      .q    (q),
      .code (code),
      .ovf  (ovf)
   );

   assign all_rdy = &sink_ready;

   fxp_pipe #(.DW(OUT_W + 1), .STAGES(STAGES)) u_pipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   ({ovf, code}),
      .out_valid (out_valid),
      .out_ready (all_rdy),
      .out_data  (head)
   );

   assign out_ovf  = head[OUT_W];
   assign out_data = head[OUT_W-1:0];

   // R9: a partially ready consumer set never lets the head leave
   a_r9_all_sinks: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !all_rdy) |=> (out_valid && $stable(out_data) && $stable(out_ovf)));
endmodule

// File: tb/fxp_requant_bench.sv
module fxp_requant_bench;
   import fxp_requant_pkg::*;

   localparam int S  = 3;
   localparam int IW = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [IW-1:0] in_data = '0;
   logic [1:0] sink_ready = 2'b11;

   logic rdy_a, rdy_b, rdy_c, rdy_d;
   logic ov_a, ov_b, ov_c, ov_d;
   logic fl_a, fl_b, fl_c, fl_d;
   logic [7:0] code_a;
   logic [5:0] code_b;
   logic [7:0] code_c;
   logic [9:0] code_d;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   bit model_on = 1'b0;
   bit mv [S];
   logic [IW-1:0] md [S];

   always #5 clk = ~clk;

   fxp_requant #(.IN_W(IW), .IN_FRAC(4), .IN_REP(REP_TWOS), .OUT_W(8), .OUT_FRAC(2),
      .OUT_REP(REP_SM), .OVF_MODE(OVF_SAT), .RND_MODE(RND_NEAR), .STAGES(S), .N_SINK(2))
   u_fxp_requant (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_a),
      .in_data(in_data), .out_valid(ov_a), .sink_ready(sink_ready), .out_data(code_a), .out_ovf(fl_a));

   fxp_requant #(.IN_W(IW), .IN_FRAC(4), .IN_REP(REP_TWOS), .OUT_W(6), .OUT_FRAC(1),
      .OUT_REP(REP_UNS), .OVF_MODE(OVF_WRAP), .RND_MODE(RND_FLOOR), .STAGES(S), .N_SINK(2))
   u_fxp_requant_b (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_b),
      .in_data(in_data), .out_valid(ov_b), .sink_ready(sink_ready), .out_data(code_b), .out_ovf(fl_b));

   fxp_requant #(.IN_W(IW), .IN_FRAC(4), .IN_REP(REP_SM), .OUT_W(8), .OUT_FRAC(3),
      .OUT_REP(REP_TWOS), .OVF_MODE(OVF_SAT), .RND_MODE(RND_CEIL), .STAGES(S), .N_SINK(2))
   u_fxp_requant_c (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_c),
      .in_data(in_data), .out_valid(ov_c), .sink_ready(sink_ready), .out_data(code_c), .out_ovf(fl_c));

   fxp_requant #(.IN_W(IW), .IN_FRAC(2), .IN_REP(REP_UNS), .OUT_W(10), .OUT_FRAC(4),
      .OUT_REP(REP_TWOS), .OVF_MODE(OVF_WRAP), .RND_MODE(RND_NEAR), .STAGES(S), .N_SINK(2))
   u_fxp_requant_d (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_d),
      .in_data(in_data), .out_valid(ov_d), .sink_ready(sink_ready), .out_data(code_d), .out_ovf(fl_d));

   // ---------------- behavioural reference ----------------
   function automatic longint decode(input int c, input int w, input int rep);
      longint full = longint'(1) << w;
      longint half = longint'(1) << (w - 1);
      if (rep == REP_UNS) return longint'(c);
      if (rep == REP_TWOS) return (longint'(c) >= half) ? longint'(c) - full : longint'(c);
      if ((longint'(c) & half) != 0) return -(longint'(c) & (half - 1));
      return longint'(c) & (half - 1);
   endfunction

   // returns code in low bits, flag in bit 20
   function automatic int conv(input int c, input int inf, input int inrep, input int w,
                               input int outf, input int rep, input int ovf, input int rnd);
      longint v = decode(c, IW, inrep);
      int sh = inf - outf;
      longint q, r, mx, mn, qc, mag, code, m;
      bit flag;
      if (sh > 0) begin
         longint dv = longint'(1) << sh;
         q = v >>> sh;
         r = v - q * dv;
         if (rnd == RND_CEIL && r != 0) q = q + 1;
         if (rnd == RND_NEAR && ((v >= 0) ? (r >= dv / 2) : (r > dv / 2))) q = q + 1;
      end else begin
         q = v * (longint'(1) << (-sh));
      end
      m = (longint'(1) << w) - 1;
      if (rep == REP_UNS) begin mx = m; mn = 0; end
      else if (rep == REP_TWOS) begin mx = (longint'(1) << (w-1)) - 1; mn = -(longint'(1) << (w-1)); end
      else begin mx = (longint'(1) << (w-1)) - 1; mn = -mx; end
      flag = (q > mx) || (q < mn);
      if (ovf == OVF_SAT) begin
         qc = (q > mx) ? mx : ((q < mn) ? mn : q);
      end else if (rep == REP_SM) begin
         mag = ((q < 0) ? -q : q) % (longint'(1) << (w-1));
         qc = (q < 0) ? -mag : mag;
      end else begin
         qc = q & m;
         if (rep == REP_TWOS && qc > mx) qc = qc - (longint'(1) << w);
      end
      if (rep == REP_SM) code = ((qc < 0) ? (longint'(1) << (w-1)) : 0) | ((qc < 0) ? -qc : qc);
      else code = qc & m;
      return int'(code) | (int'(flag) << 20);
   endfunction

   task automatic chk(input bit ok, input string msg, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
      end
   endtask

   // per-cycle comparison against the slot model, then model advance
   always @(negedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < S; i++) mv[i] = 1'b0;
      end else if (model_on) begin
         bit r [S+1];
         int e;
         r[S] = &sink_ready;
         for (int i = S - 1; i >= 0; i--) r[i] = !mv[i] || r[i+1];
         chk(rdy_a == r[0] && rdy_b == r[0] && rdy_c == r[0] && rdy_d == r[0],
             "R11 in_ready vs model", int'(rdy_a), int'(r[0]));
         chk(ov_a == mv[S-1] && ov_b == mv[S-1] && ov_c == mv[S-1] && ov_d == mv[S-1],
             "R10 R12 out_valid vs model", int'(ov_a), int'(mv[S-1]));
         if (mv[S-1] && ov_a) begin
            e = conv(int'(md[S-1]), 4, REP_TWOS, 8, 2, REP_SM, OVF_SAT, RND_NEAR);
            chk({fl_a, code_a} == 9'(((e >> 20) << 8) | (e & 255)), "R4 R5 R8 inst A data",
                int'({fl_a, code_a}), ((e >> 20) << 8) | (e & 255));
            e = conv(int'(md[S-1]), 4, REP_TWOS, 6, 1, REP_UNS, OVF_WRAP, RND_FLOOR);
            chk({fl_b, code_b} == 7'(((e >> 20) << 6) | (e & 63)), "R3 R6 R8 inst B data",
                int'({fl_b, code_b}), ((e >> 20) << 6) | (e & 63));
            e = conv(int'(md[S-1]), 4, REP_SM, 8, 3, REP_TWOS, OVF_SAT, RND_CEIL);
            chk({fl_c, code_c} == 9'(((e >> 20) << 8) | (e & 255)), "R1 R3 R5 inst C data",
                int'({fl_c, code_c}), ((e >> 20) << 8) | (e & 255));
            e = conv(int'(md[S-1]), 2, REP_UNS, 10, 4, REP_TWOS, OVF_WRAP, RND_NEAR);
            chk({fl_d, code_d} == 11'(((e >> 20) << 10) | (e & 1023)), "R2 R6 inst D data",
                int'({fl_d, code_d}), ((e >> 20) << 10) | (e & 1023));
         end
         for (int i = S - 1; i >= 0; i--) begin
            if (r[i]) begin
               if (i == 0) begin
                  mv[0] = in_valid;
                  if (in_valid) md[0] = in_data;
               end else begin
                  mv[i] = mv[i-1];
                  if (mv[i-1]) md[i] = md[i-1];
               end
            end
         end
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic send(input logic [IW-1:0] c);
      @(posedge clk); #1;
      in_valid = 1'b1;
      in_data  = c;
      forever begin
         @(negedge clk);
         if (rdy_a) break;
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   task automatic wait_out(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!ov_a && n < 50);
   endtask

   task automatic vec(input logic [IW-1:0] c, input int ea, input int fa, input int eb, input int fb,
                      input int ec, input int fc, input int ed, input int fd, input string tag);
      int n;
      send(c);
      wait_out(n);
      if (ea >= 0) chk(code_a == 8'(ea) && fl_a == 1'(fa), {tag, " inst A"}, int'({fl_a, code_a}), (fa << 8) | ea);
      if (eb >= 0) chk(code_b == 6'(eb) && fl_b == 1'(fb), {tag, " inst B"}, int'({fl_b, code_b}), (fb << 6) | eb);
      if (ec >= 0) chk(code_c == 8'(ec) && fl_c == 1'(fc), {tag, " inst C"}, int'({fl_c, code_c}), (fc << 8) | ec);
      if (ed >= 0) chk(code_d == 10'(ed) && fl_d == 1'(fd), {tag, " inst D"}, int'({fl_d, code_d}), (fd << 10) | ed);
   endtask

   initial begin
      int n, acc;
      logic [7:0] held;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      model_on = 1'b1;
      repeat (3) begin
         @(negedge clk);
         chk(!ov_a && rdy_a, "R12 reset state valid=0 ready=1", int'({ov_a, rdy_a}), 1);
      end

      // R10: latency through an empty pipeline
      send(12'h018);
      @(negedge clk); n = 1;
      while (!ov_a && n < 20) begin @(negedge clk); n++; end
      chk(n == S, "R10 latency in edges", n, S);
      repeat (3) @(negedge clk);

      // directed conversions
      vec(12'h018, 8'h06, 0, -1, 0, -1, 0, -1, 0, "R8 exact 1.5");
      vec(12'h016, 8'h06, 0, -1, 0, -1, 0, -1, 0, "R4 tie positive");
      vec(12'hFEA, 8'h86, 0, -1, 0, -1, 0, -1, 0, "R4 tie negative");
      vec(12'hFFF, 8'h00, 0, 6'h3F, 1, -1, 0, -1, 0, "R7 R6 small negative");
      vec(12'h7FF, 8'h7F, 1, -1, 0, 8'h7F, 1, 10'h3FC, 1, "R5 R6 top code");
      vec(12'h800, 8'hFF, 1, -1, 0, 8'h00, 0, 10'h000, 1, "R5 R1 R6 bottom code");
      vec(12'h018, 8'h06, 0, -1, 0, -1, 0, -1, 0, "R8 flag clears");
      vec(12'hFF8, 8'h82, 0, 6'h3F, 1, -1, 0, -1, 0, "R6 negative to unsigned");
      vec(12'h064, 8'h19, 0, 6'h0C, 0, -1, 0, 10'h190, 0, "R3 R2 floor and left shift");
      vec(12'h3E8, 8'h7F, 1, 6'h3D, 1, -1, 0, -1, 0, "R6 R5 large value");
      vec(12'h805, 8'hFF, 1, -1, 0, 8'hFE, 0, -1, 0, "R3 R1 ceil negative");
      vec(12'h005, 8'h01, 0, -1, 0, 8'h03, 0, -1, 0, "R3 ceil positive");
      vec(12'h07F, 8'h20, 0, -1, 0, -1, 0, 10'h1FC, 0, "R2 exact left shift");
      repeat (4) @(negedge clk);

      // R9 R11: one consumer blocks, pipeline fills
      @(posedge clk); #1;
      sink_ready = 2'b01;
      acc = 0;
      for (int k = 0; k < 6; k++) begin
         in_valid = 1'b1;
         in_data  = 12'(16 * k + 3);
         @(negedge clk);
         if (rdy_a) acc++;
         @(posedge clk); #1;
      end
      in_valid = 1'b0;
      chk(acc == S, "R11 accepted while blocked", acc, S);
      @(negedge clk);
      held = code_a;
      repeat (4) @(negedge clk);
      chk(ov_a && code_a == held, "R9 head held while one sink low", int'(code_a), int'(held));
      chk(!rdy_a, "R11 refused when full and blocked", int'(rdy_a), 0);
      @(posedge clk); #1 sink_ready = 2'b11;
      repeat (6) @(negedge clk);

      // R12: reset with a full pipeline
      @(posedge clk); #1 sink_ready = 2'b00; in_valid = 1'b1; in_data = 12'h123;
      repeat (5) @(posedge clk);
      #1 in_valid = 1'b0; rst_n = 1'b0;
      @(negedge clk);
      chk(!ov_a, "R12 reset empties stages", int'(ov_a), 0);
      @(posedge clk); #1 rst_n = 1'b1; sink_ready = 2'b11;
      repeat (6) begin
         @(negedge clk);
         chk(!ov_a, "R12 no output without new input", int'(ov_a), 0);
      end

      // random traffic against the model
      for (int k = 0; k < 800; k++) begin
         @(posedge clk); #1;
         in_valid   = ($urandom % 3) != 0;
         in_data    = 12'($urandom);
         sink_ready = 2'($urandom % 4) | (($urandom % 2) != 0 ? 2'b11 : 2'b00);
      end
      @(posedge clk); #1 in_valid = 1'b0; sink_ready = 2'b11;
      repeat (8) @(negedge clk);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule